// File: doc/BRIEF.md
# Dual-Port GPIO with Interrupt Detection

This block provides two 8-line general-purpose I/O ports, called port 0 and port 1, on one byte-wide register bus. Each port has a data latch, a direction mask, and a per-line interrupt setup. The setup uses an enable mask, a mode mask that picks level or edge, and a polarity mask that picks low/falling or high/rising. Together these give four trigger behaviours for each line.

Every pad input first passes through a two-flop synchroniser, and detection works only on the synchronised value. Each port has a read-only pending register. In level mode a pending bit follows the qualified input. In edge mode a pending bit latches the edge and stays set until software writes a one to the same bit of the port's clear register. The pending bits of both ports are ORed onto one interrupt output. A host writes the masks once, then services `irq` by reading the two pending registers and clearing the edge bits it has handled.

Top module: `gpio_dual_irq`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0, `pad_out` and `pad_oe` are all 0, and `irq` is 0.
- R2: Global line n belongs to port n/8 at bit n mod 8, so `pad_in[7:0]` is port 0 and `pad_in[15:8]` is port 1. The register address is formed as follows:
  - `reg_addr[3]` selects the port.
  - `reg_addr[2:0]` selects the register: 0 data, 1 direction, 2 enable, 3 mode, 4 polarity, 5 pending (read-only), 6 clear (write-only, reads 0).
- R3: A direction bit of 1 makes its line an output: `pad_oe` shows the direction mask and `pad_out` shows the data latch. Reading the data register returns the latch bit for output lines and the synchronised pad for input lines.
- R4: A pad change that is applied between edges reaches the data register read value after exactly two rising clock edges.
- R5: With mode bit 0 (level), an enabled line is pending while its synchronised input is high (polarity 1) or low (polarity 0), and it stops being pending when that level goes away.
- R6: With mode bit 1 (edge), an enabled line becomes pending on a rising edge (polarity 1) or a falling edge (polarity 0) and stays pending afterwards. Enabling a line whose input is steady raises nothing.
- R7: Writing 1 to a bit of the clear register ends an edge-mode pending bit. It has no effect on a level-mode pending bit while the level persists.
- R8: A line whose enable bit is 0 never sets its pending bit. Changing its mode or polarity while it is disabled raises no interrupt, and clearing the enable bit drops that line's pending bit.
- R9: A clear write to a bit in the same cycle as a new qualifying edge on that bit leaves the pending bit set.
- R10: `irq` is the OR of all pending bits of both ports.
- R11: Writes to the pending register change nothing, and the clear register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 4 | Port select (bit 3) and register select (bits 2:0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pad_in | input | 16 | Asynchronous pad inputs, port 1 in the upper byte |
| pad_out | output | 16 | Output values from the data latches |
| pad_oe | output | 16 | Output enables from the direction masks |
| irq | output | 1 | Combined pending interrupt |

## Verification
The detector assertions treat the synchronised pad value as stable for a whole cycle. They also expect a clear pulse to last exactly one cycle, since it comes from a single-cycle write strobe. To stay within these limits, the stimulus changes pads and register strobes only on falling clock edges and drops `reg_wr` after one cycle. It then waits long enough for the synchroniser and the pending flop before sampling. The same-cycle race for R9 is produced on purpose by counting edges from the pad change, so that the clear write lands on the cycle where the synchronised edge appears.

// File: rtl/gpio_pkg.sv
// gpio_pkg: shared register-select encoding for the dual GPIO block.
// Assumes a 3-bit register selector inside each port's address window.
package gpio_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_IEN  = 3'd2,
        SEL_MODE = 3'd3,
        SEL_POL  = 3'd4,
        SEL_PEND = 3'd5,
        SEL_CLR  = 3'd6
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is synchronised on its own; no multi-bit coherence.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [1:0]   age_q;

    // Two-stage capture of the pad values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    // Cycles since reset, saturating at two, used only to arm the check below.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= 2'd0;
        else if (age_q != 2'd2)
            age_q <= age_q + 2'd1;
    end

    assign dout = sync_q;

    // Synchronised value equals the pad value two edges earlier.
    assert_two_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_irq_detect.sv
// gpio_irq_detect: per-line level/edge interrupt detector with sticky edge status.
// Assumes pin is already synchronous to clk and ack is a one-cycle pulse.
module gpio_irq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] en,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] ack,
    output logic [W-1:0] status
);

    logic [W-1:0] pin_d;
    logic [W-1:0] qual;
    logic [W-1:0] hit;
    logic [W-1:0] st_d;
    logic [W-1:0] st_q;

    // Previous synchronised value, tracked even while disabled so enabling sees no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_d <= '0;
        else
            pin_d <= pin;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        assign qual[i] = pol[i] ? pin[i] : ~pin[i];
        assign hit[i]  = pol[i] ? (pin[i] & ~pin_d[i]) : (~pin[i] & pin_d[i]);
        assign st_d[i] = !en[i]  ? 1'b0 :
                         mode[i] ? (hit[i] | (st_q[i] & ~ack[i])) :
                                   qual[i];
    end

    // Pending status register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign status = st_q;

    // A line disabled in the previous cycle is not pending.
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(en)) == '0));

    // Edge status stays set without a clear.
    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status & en & mode & ~ack) & ~status) == '0));

    // A clear without a fresh edge drops edge status.
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status & en & mode & ack & ~hit) & status) == '0));

    // A fresh edge wins over a simultaneous clear.
    assert_ack_race_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(en & mode & hit) & ~status) == '0));

    // An active level on an enabled level-mode line is pending next cycle.
    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(en & ~mode & ~(pin ^ pol)) & ~status) == '0));

endmodule

// File: rtl/gpio_port.sv
// gpio_port: one GPIO port with data, direction and interrupt-setup registers.
// Assumes wr_en is already qualified by this port's address window.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     rdata,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pend,
    output logic [W-1:0]     ien
);

    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] ien_q;
    logic [W-1:0] mode_q;
    logic [W-1:0] pol_q;
    logic [W-1:0] pin_s;
    logic [W-1:0] clr_v;

    gpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_s)
    );

    // Register writes; the pending register has no write path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            ien_q  <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA: data_q <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_IEN:  ien_q  <= wdata;
                SEL_MODE: mode_q <= wdata;
                SEL_POL:  pol_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // One-cycle clear pulse from a write to the clear register.
    assign clr_v = (wr_en && sel == SEL_CLR) ? wdata : '0;

    gpio_irq_detect #(.W(W)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (pin_s),
        .en     (ien_q),
        .mode   (mode_q),
        .pol    (pol_q),
        .ack    (clr_v),
        .status (pend)
    );

    // Read multiplexer; clear and unused selects read zero.
    always_comb begin
        case (sel)
            SEL_DATA: rdata = (dir_q & data_q) | (~dir_q & pin_s);
            SEL_DIR:  rdata = dir_q;
            SEL_IEN:  rdata = ien_q;
            SEL_MODE: rdata = mode_q;
            SEL_POL:  rdata = pol_q;
            SEL_PEND: rdata = pend;
            default:  rdata = '0;
        endcase
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
    assign ien     = ien_q;

endmodule

// File: rtl/gpio_dual_irq.sv
// gpio_dual_irq: PORTS GPIO ports on one register bus with a combined interrupt.
// Assumes the bus width equals LINES and reads are combinational.
module gpio_dual_irq
    import gpio_pkg::*;
#(
    parameter  int PORTS  = 2,
    parameter  int LINES  = 8,
    localparam int PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int ADDR_W = SEL_W + PSEL_W,
    localparam int NPINS  = PORTS * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);

    logic [PSEL_W-1:0] port_sel;
    logic [SEL_W-1:0]  reg_sel;
    logic [LINES-1:0]  port_rd [PORTS];
    logic [NPINS-1:0]  pend_all;
    logic [NPINS-1:0]  ien_all;

    assign port_sel = reg_addr[ADDR_W-1:SEL_W];
    assign reg_sel  = reg_addr[SEL_W-1:0];

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic we;
        assign we = reg_wr && (port_sel == PSEL_W'(p));

        gpio_port #(.W(LINES)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (we),
            .sel     (reg_sel),
            .wdata   (reg_wdata),
            .pad_in  (pad_in[p*LINES +: LINES]),
            .rdata   (port_rd[p]),
            .pad_out (pad_out[p*LINES +: LINES]),
            .pad_oe  (pad_oe[p*LINES +: LINES]),
            .pend    (pend_all[p*LINES +: LINES]),
            .ien     (ien_all[p*LINES +: LINES])
        );
    end

    // Select the addressed port's read data; unmapped ports read zero.
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < PORTS; p++)
            if (port_sel == PSEL_W'(p))
                reg_rdata = port_rd[p];
    end

    assign irq = |pend_all;

    // The interrupt needs some line enabled in the cycle that set it.
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|$past(ien_all)));

endmodule

// File: tb/tb_gpio_dual_irq.sv
`timescale 1ns/1ps
module tb_gpio_dual_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_dual_irq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  waddr;
        logic [7:0]  wdata;
        logic [15:0] pad;
        logic [3:0]  raddr;
        logic [7:0]  exp;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    // Row: write?, addr, data, pads, read addr, expected read, expected irq, requirement.
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'h1, 8'hF0, 16'h0000, 4'h1, 8'hF0, 1'b0, 4'd3},  // R3 direction
        '{1'b1, 4'h0, 8'hA5, 16'h0000, 4'h0, 8'hA0, 1'b0, 4'd3},  // R3 mixed read
        '{1'b0, 4'h0, 8'h00, 16'h000F, 4'h0, 8'hAF, 1'b0, 4'd4},  // R4 inputs seen
        '{1'b1, 4'h9, 8'h00, 16'h030F, 4'h8, 8'h03, 1'b0, 4'd2},  // R2 port 1 mapping
        '{1'b1, 4'hC, 8'h01, 16'h030F, 4'hD, 8'h00, 1'b0, 4'd8},  // R8 disabled
        '{1'b1, 4'hA, 8'h01, 16'h030F, 4'hD, 8'h01, 1'b1, 4'd5},  // R5 high level, R10
        '{1'b0, 4'h0, 8'h00, 16'h020F, 4'hD, 8'h00, 1'b0, 4'd5},  // R5 level gone
        '{1'b1, 4'hC, 8'h00, 16'h020F, 4'hD, 8'h01, 1'b1, 4'd5},  // R5 low level
        '{1'b1, 4'hE, 8'h01, 16'h020F, 4'hD, 8'h01, 1'b1, 4'd7},  // R7 level ignores clear
        '{1'b1, 4'hA, 8'h00, 16'h020F, 4'hD, 8'h00, 1'b0, 4'd8},  // R8 disable drops
        '{1'b1, 4'h3, 8'h03, 16'h020F, 4'h5, 8'h00, 1'b0, 4'd8},  // R8 mode change
        '{1'b1, 4'h4, 8'h01, 16'h020F, 4'h5, 8'h00, 1'b0, 4'd8},  // R8 polarity change
        '{1'b1, 4'h2, 8'h03, 16'h020F, 4'h5, 8'h00, 1'b0, 4'd6},  // R6 steady enable
        '{1'b0, 4'h0, 8'h00, 16'h020C, 4'h5, 8'h02, 1'b1, 4'd6},  // R6 falling, R10
        '{1'b0, 4'h0, 8'h00, 16'h020F, 4'h5, 8'h03, 1'b1, 4'd6},  // R6 rising
        '{1'b0, 4'h0, 8'h00, 16'h020C, 4'h5, 8'h03, 1'b1, 4'd6},  // R6 sticky
        '{1'b1, 4'h6, 8'h02, 16'h020C, 4'h5, 8'h01, 1'b1, 4'd7},  // R7 clear bit 1
        '{1'b1, 4'h6, 8'h01, 16'h020C, 4'h5, 8'h00, 1'b0, 4'd7},  // R7 clear bit 0
        '{1'b1, 4'h5, 8'hFF, 16'h020C, 4'h5, 8'h00, 1'b0, 4'd11}, // R11 pending read-only
        '{1'b0, 4'h0, 8'h00, 16'h020C, 4'h6, 8'h00, 1'b0, 4'd11}  // R11 clear reads 0
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) rd_check("R1 register", 4'(a), 8'h00);
        check("R1 pad_oe", pad_oe, 16'h0000);
        check("R1 pad_out", pad_out, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);

        // R4 two-edge synchroniser latency
        pad_in = 16'h0001;
        reg_addr = 4'h0;
        @(negedge clk); #1;
        check("R4 after one edge", {8'h00, reg_rdata}, 16'h0000);
        @(negedge clk); #1;
        check("R4 after two edges", {8'h00, reg_rdata}, 16'h0001);
        pad_in = 16'h0000;
        settle();

        // Vector table
        for (int i = 0; i < NV; i++) begin
            pad_in = VECS[i].pad;
            if (VECS[i].wr) wr(VECS[i].waddr, VECS[i].wdata);
            settle();
            rd_check($sformatf("R%0d row %0d read", VECS[i].req, i), VECS[i].raddr, VECS[i].exp);
            check($sformatf("R%0d row %0d irq", VECS[i].req, i), {15'd0, irq}, {15'd0, VECS[i].exp_irq});
        end

        // R3 pad drive follows latch and direction
        check("R3 pad_oe", pad_oe, 16'h00F0);
        check("R3 pad_out", {8'h00, pad_out[7:0]}, 16'h00A5);

        // R9 clear in the same cycle as a new rising edge on port 0 line 0
        pad_in = 16'h020D;
        settle();
        rd_check("R6 rising latched", 4'h5, 8'h01);
        pad_in = 16'h020C;
        settle();
        wr(4'h6, 8'h01);
        settle();
        rd_check("R7 cleared before race", 4'h5, 8'h00);
        pad_in = 16'h020D;
        @(negedge clk);
        @(negedge clk);
        wr(4'h6, 8'h01);
        settle();
        rd_check("R9 edge beats clear", 4'h5, 8'h01);

        // R10 both ports pending, then one at a time
        wr(4'hA, 8'h01);
        settle();
        rd_check("R10 port 1 pending", 4'hD, 8'h01);
        check("R10 irq both", {15'd0, irq}, 16'h0001);
        wr(4'h6, 8'h01);
        settle();
        check("R10 irq port 1 only", {15'd0, irq}, 16'h0001);
        wr(4'hA, 8'h00);
        settle();
        check("R10 irq none", {15'd0, irq}, 16'h0000);

        finish_run();
    end

endmodule